// File: doc/BRIEF.md
# Keyed-Write Watchdog Interval Timer

An 8-bit interval timer with an overflow interrupt. A control/status byte and a count byte share one 16-bit write port. A word write lands in a register only when its high byte holds the right key: one key selects the control/status byte and another selects the count. Any other word write, and any byte-wide write, has no effect.

Counting runs from a prescaler. Its period is a base of 32 peripheral clocks shifted left by a 3-bit select field. The host reports on `adv_i` how many peripheral clocks went by in each cycle. The prescaler adds that amount to its remainder and releases every whole tick the sum holds. The leftover clocks stay for the next cycle.

When the count wraps past 0xFF, the block does three things. It sets a sticky overflow flag and pulses `irq_o` for one cycle. It presents an interrupt level and a 7-bit vector, both taken from priority and vector bytes that neighbouring registers supply. A read multiplexer returns either register.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control/status byte reads 0x00, the count reads 0x00 and `irq_o` is 0.
- R2: A word write (`wr_word_i`=1) with `wr_data_i[15:8]`=0xA5 loads `wr_data_i[6:0]` into control/status bits [6:0]. Bit 5 is the run enable and bits [2:0] are the clock select. The byte reads back on `rd_data_o` when `rd_sel_i`=0.
- R3: A word write with `wr_data_i[15:8]`=0x5A loads `wr_data_i[7:0]` into the count. The count reads back when `rd_sel_i`=1.
- R4: A write with any other high byte, or with `wr_word_i`=0, changes neither register.
- R5: While control/status bit 5 is 0 the count does not change, whatever `adv_i` carries.
- R6: While running, one tick takes `32 << sel` peripheral clocks. Each cycle adds `adv_i` clocks, and every tick adds 1 to the count.
- R7: When one cycle's `adv_i` covers several ticks, all of them are added. The clocks left over are carried into the following cycles.
- R8: A wrap of the count from 0xFF to 0x00 sets control/status bit 7 and raises `irq_o` for the one cycle that follows. `irq_level_o` carries `prio_i[7:4]` and `irq_vector_o` carries `vec_i[6:0]`.
- R9: Bit 7 is cleared only by a control write whose data bit 7 is 0. A control write with bit 7 equal to 1 leaves the flag unchanged, and a write can never set it.
- R10: A control write that changes the clock select clears the prescaler remainder.
- R11: If a count write and a tick fall in the same cycle, the written value is kept and that cycle's ticks are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_word_i | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_data_i | input | 16 | Key in [15:8], payload in [7:0] |
| rd_sel_i | input | 1 | 0 = control/status, 1 = count |
| rd_data_o | output | 8 | Selected register |
| adv_i | input | 8 | Peripheral clocks elapsed this cycle |
| prio_i | input | 8 | Priority byte; level is the upper nibble |
| vec_i | input | 8 | Vector byte; vector is bits [6:0] |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |
| irq_level_o | output | 4 | Interrupt level |
| irq_vector_o | output | 7 | Interrupt vector |

## Verification
A stale or uncleared prescaler remainder shows at the ports as a count that steps one tick early or late. The error is visible on the read of the cycle right after the `adv_i` value that crosses the boundary, so the bench lands its updates exactly on, and just short of, the tick edges. A wrong overflow flag shows on the control/status read and on `irq_o` one cycle after the wrapping update. A decode fault shows on the read-back after a single rejected write.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [7:0] KEY_CTL   = 8'hA5;
  localparam logic [7:0] KEY_CNT   = 8'h5A;
  localparam int         OVF_BIT   = 7;
  localparam int         RUN_BIT   = 5;
  localparam int         SEL_LSB   = 0;
endpackage

// File: rtl/keyed_wdt_decode.sv
module keyed_wdt_decode (
  input  logic        wr_en_i,
  input  logic        wr_word_i,
  input  logic [15:0] wr_data_i,
  output logic        ctl_we_o,
  output logic        cnt_we_o,
  output logic [7:0]  data_o
);
  import keyed_wdt_pkg::*;
  logic word_wr;
  assign word_wr  = wr_en_i & wr_word_i;
  assign ctl_we_o = word_wr & (wr_data_i[15:8] == KEY_CTL);
  assign cnt_we_o = word_wr & (wr_data_i[15:8] == KEY_CNT);
  assign data_o   = wr_data_i[7:0];
endmodule

// File: rtl/keyed_wdt_ctl.sv
module keyed_wdt_ctl #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       data_i,
  input  logic             ovf_set_i,
  output logic [7:0]       csr_o,
  output logic             run_o,
  output logic [DIV_W-1:0] sel_o,
  output logic             sel_chg_o
);
  import keyed_wdt_pkg::*;
  logic [7:0] csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
    end else begin
      if (we_i) csr_q[OVF_BIT-1:0] <= data_i[OVF_BIT-1:0];
      // flag: set by wrap, cleared only by a keyed write of 0
      csr_q[OVF_BIT] <= ovf_set_i | (csr_q[OVF_BIT] & (~we_i | data_i[OVF_BIT]));
    end
  end

  assign csr_o     = csr_q;
  assign run_o     = csr_q[RUN_BIT];
  assign sel_o     = csr_q[SEL_LSB +: DIV_W];
  assign sel_chg_o = we_i & (data_i[SEL_LSB +: DIV_W] != csr_q[SEL_LSB +: DIV_W]);
endmodule

// File: rtl/keyed_wdt_presc.sv
module keyed_wdt_presc #(
  parameter int DIV_W      = 3,
  parameter int BASE_SHIFT = 5,
  parameter int STEP_W     = 8,
  localparam int ACC_W     = BASE_SHIFT + (1 << DIV_W) - 1,
  localparam int SUM_W     = ACC_W + 1,
  localparam int TICK_W    = SUM_W - BASE_SHIFT,
  localparam int SH_W      = $clog2(SUM_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  sel_i,
  input  logic              clr_i,
  input  logic [STEP_W-1:0] adv_i,
  output logic [TICK_W-1:0] ticks_o
);
  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum, mask, shifted;
  logic [SH_W-1:0]  sh;

  always_comb begin
    sh      = SH_W'(BASE_SHIFT) + SH_W'(sel_i);
    sum     = SUM_W'(acc_q) + SUM_W'(adv_i);
    mask    = (SUM_W'(1) << sh) - SUM_W'(1);
    shifted = sum >> sh;
    ticks_o = run_i ? shifted[TICK_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (run_i)  acc_q <= ACC_W'(sum & mask);
  end
endmodule

// File: rtl/keyed_wdt_count.sv
module keyed_wdt_count #(
  parameter int CNT_W  = 8,
  parameter int TICK_W = 8,
  localparam int SUM_W = ((CNT_W > TICK_W) ? CNT_W : TICK_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic [TICK_W-1:0] ticks_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_set_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;
  logic             irq_q;

  assign sum       = SUM_W'(cnt_q) + SUM_W'(ticks_i);
  assign ovf_set_o = ~load_i & (|sum[SUM_W-1:CNT_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= load_i ? load_val_i : sum[CNT_W-1:0];
      irq_q <= ovf_set_o;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DIV_W      = 3,
  parameter int BASE_SHIFT = 5,
  parameter int STEP_W     = 8,
  parameter int LVL_W      = 4,
  parameter int VEC_W      = 7,
  localparam int CNT_W     = 8,
  localparam int ACC_W     = BASE_SHIFT + (1 << DIV_W) - 1,
  localparam int TICK_W    = ACC_W + 1 - BASE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_word_i,
  input  logic [15:0]       wr_data_i,
  input  logic              rd_sel_i,
  output logic [7:0]        rd_data_o,
  input  logic [STEP_W-1:0] adv_i,
  input  logic [7:0]        prio_i,
  input  logic [7:0]        vec_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [VEC_W-1:0]  irq_vector_o
);
  logic              ctl_we, cnt_we, run, sel_chg, ovf_set;
  logic [7:0]        wdata, csr_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [DIV_W-1:0]  sel;
  logic [TICK_W-1:0] ticks;

  keyed_wdt_decode u_dec (
    .wr_en_i, .wr_word_i, .wr_data_i,
    .ctl_we_o(ctl_we), .cnt_we_o(cnt_we), .data_o(wdata)
  );

  keyed_wdt_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk_i, .rst_ni, .we_i(ctl_we), .data_i(wdata), .ovf_set_i(ovf_set),
    .csr_o(csr_w), .run_o(run), .sel_o(sel), .sel_chg_o(sel_chg)
  );

  keyed_wdt_presc #(.DIV_W(DIV_W), .BASE_SHIFT(BASE_SHIFT), .STEP_W(STEP_W)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .sel_i(sel), .clr_i(sel_chg),
    .adv_i, .ticks_o(ticks)
  );

  keyed_wdt_count #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_we), .load_val_i(wdata), .ticks_i(ticks),
    .cnt_o(cnt_w), .ovf_set_o(ovf_set), .irq_o
  );

  assign rd_data_o    = rd_sel_i ? cnt_w : csr_w;
  assign irq_level_o  = prio_i[7 -: LVL_W];
  assign irq_vector_o = vec_i[VEC_W-1:0];
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_word_i,
  input logic [15:0] wr_data_i,
  input logic [7:0]  csr_i,
  input logic [7:0]  cnt_i,
  input logic        irq_o
);
  logic ctl_wr, cnt_wr;
  assign ctl_wr = wr_en_i && wr_word_i && (wr_data_i[15:8] == 8'hA5);
  assign cnt_wr = wr_en_i && wr_word_i && (wr_data_i[15:8] == 8'h5A);

  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> csr_i[6:0] == $past(wr_data_i[6:0])); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_i == $past(wr_data_i[7:0])); // R3
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr |=> csr_i[6:0] == $past(csr_i[6:0])); // R4
  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_i[5] && !cnt_wr) |=> $stable(cnt_i)); // R5
  AST_FLAG_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csr_i[7]) |-> irq_o); // R8
  AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> csr_i[7]); // R8
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr_i[7]) |-> $past(ctl_wr && !wr_data_i[7])); // R9
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_word_i, .wr_data_i,
  .csr_i(csr_w), .cnt_i(cnt_w), .irq_o
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_word = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  adv = '0, prio = '0, vec = '0;
  logic [7:0]  rd_data;
  logic        irq;
  logic [3:0]  irq_level;
  logic [6:0]  irq_vector;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_word_i(wr_word),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .adv_i(adv),
    .prio_i(prio), .vec_i(vec), .irq_o(irq), .irq_level_o(irq_level),
    .irq_vector_o(irq_vector)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic word, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_word = word; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_word = 1'b0;
  endtask

  task automatic step(input logic [7:0] n, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); adv = n;
    end
    @(negedge clk); adv = '0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1 csr", v, 8'h00);
    rd(1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_keys;
    logic [7:0] v;
    wr(1, 16'hA521); rd(0, v); chk("R2 ctl load", v, 8'h21);
    wr(1, 16'hA500); rd(0, v); chk("R2 ctl reload", v, 8'h00);
    wr(1, 16'h5A37); rd(1, v); chk("R3 cnt load", v, 8'h37);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(1, 16'h12FF); rd(0, v); chk("R4 bad key csr", v, 8'h00);
    wr(0, 16'hA53F); rd(0, v); chk("R4 byte write csr", v, 8'h00);
    wr(0, 16'h5A99); rd(1, v); chk("R4 byte write cnt", v, 8'h37);
    wr(1, 16'h5BAA); rd(1, v); chk("R4 bad key cnt", v, 8'h37);
  endtask

  task automatic t_stopped;
    logic [7:0] v;
    step(8'd200, 10); rd(1, v); chk("R5 stopped", v, 8'h37);
  endtask

  task automatic t_period;
    logic [7:0] v;
    wr(1, 16'h5A00); wr(1, 16'hA520);
    step(8'd1, 31); rd(1, v); chk("R6 31 of 32", v, 8'h00);
    step(8'd1, 1);  rd(1, v); chk("R6 tick at 32", v, 8'h01);
    wr(1, 16'hA522);
    step(8'd64, 1); rd(1, v); chk("R6 sel2 half", v, 8'h01);
    step(8'd64, 1); rd(1, v); chk("R6 sel2 tick at 128", v, 8'h02);
  endtask

  task automatic t_multi;
    logic [7:0] v;
    wr(1, 16'hA520);
    step(8'd100, 1); rd(1, v); chk("R7 three ticks", v, 8'h05);
    step(8'd28, 1);  rd(1, v); chk("R7 carried remainder", v, 8'h06);
  endtask

  task automatic t_selclr;
    logic [7:0] v;
    step(8'd20, 1); rd(1, v); chk("R10 partial", v, 8'h06);
    wr(1, 16'hA521);
    step(8'd50, 1); rd(1, v); chk("R10 remainder cleared", v, 8'h06);
    step(8'd14, 1); rd(1, v); chk("R10 tick at 64", v, 8'h07);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    prio = 8'hB3; vec = 8'hC5;
    wr(1, 16'h5AFE);
    step(8'd64, 1); rd(1, v); chk("R8 at FF", v, 8'hFF); chk("R8 no irq", irq, 0);
    step(8'd64, 1); rd(1, v); chk("R8 wrapped", v, 8'h00);
    chk("R8 irq", irq, 1);
    chk("R8 level", irq_level, 4'hB);
    chk("R8 vector", irq_vector, 7'h45);
    rd(0, v); chk("R8 flag", v, 8'hA1);
    @(negedge clk); chk("R8 irq one cycle", irq, 0);
  endtask

  task automatic t_flag;
    logic [7:0] v;
    wr(1, 16'hA5A1); rd(0, v); chk("R9 write 1 keeps", v, 8'hA1);
    wr(1, 16'hA521); rd(0, v); chk("R9 write 0 clears", v, 8'h21);
    wr(1, 16'hA5A1); rd(0, v); chk("R9 cannot set", v, 8'h21);
  endtask

  task automatic t_precedence;
    logic [7:0] v;
    @(negedge clk); wr_en = 1'b1; wr_word = 1'b1; wr_data = 16'h5A10; adv = 8'd64;
    @(negedge clk); wr_en = 1'b0; wr_word = 1'b0; adv = '0;
    rd(1, v); chk("R11 write wins", v, 8'h10);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_ignored();
    t_stopped();
    t_period();
    t_multi();
    t_selclr();
    t_overflow();
    t_flag();
    t_precedence();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule